// File: doc/BRIEF.md
# SPI EEPROM Page Write Sequencer

This block programs a run of bytes into a serial EEPROM over a four-wire SPI link without help from software. A single start pulse hands it a 16-bit byte address and a byte count. It waits until the device reports that it is idle. It then splits the run into bursts that never cross a 64-byte page. Each burst consists of a write-enable frame followed by a program frame. After each burst it polls the device's status register until the internal write cycle finishes.

Payload bytes come from a valid/ready source. In erase mode the block never accepts bytes from that source and sends 0xFF in their place. If the device stays busy for too many consecutive status reads, the block stops the operation, releases the device and reports a timeout. Chip select is always held high for a programmable minimum number of cycles between frames.

Top module: `spi_ee_page_writer`

## Requirements
- R1: After reset, and whenever no operation is in progress, chip select is high, the serial clock is low, `busy_o`, `done_o`, `timeout_o` and `in_ready_o` are low, and a new operation can begin.
- R2: Before the first write-enable of an operation, the block reads the status register until a read returns bit 0 (write in progress) as 0. A status read is one frame: opcode 0x05 followed by one dummy byte, and the status value is the byte received during the dummy byte.
- R3: Each burst is one frame containing only the write-enable opcode 0x06. Chip select then returns high. The next frame carries the program opcode 0x02, then the 16-bit address with the high byte first, then the data bytes.
- R4: A burst ends after the byte whose successor address has its low 6 bits equal to zero, or after the last byte of the count. For `len_i` > 0 the number of program frames is ((addr+len-1)>>6) - (addr>>6) + 1. A count of zero performs only the initial status poll.
- R5: After every burst, chip select goes high and the status register is polled as in R2. This repeats until the busy bit clears, and only then does the next write-enable or the completion follow.
- R6: SPI mode 0, most significant bit first. The data line changes only while the clock is low, the clock is low whenever chip select is high, and the input line is sampled at the end of the clock-high phase.
- R7: When `erase_i` is high at start, every data byte sent is 0xFF and `in_ready_o` never rises during that operation.
- R8: In normal mode each data byte is taken from `in_data_i` in a cycle where both `in_valid_i` and `in_ready_o` are high. Bytes are sent in acceptance order and source stalls are tolerated. `in_ready_o` is high only while chip select is low.
- R9: When POLL_MAX consecutive status reads within one poll phase all report busy, the block raises chip select and ends the operation with `done_o` and `timeout_o` both set.
- R10: Between any two frames chip select stays high for at least CS_GAP clock cycles.
- R11: `busy_o` rises in the cycle after an accepted start and stays high until completion. A start while busy is ignored. `done_o` (and `timeout_o` if set) stay high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when not busy |
| erase_i | input | 1 | Erase mode select, sampled at start |
| addr_i | input | 16 | First byte address |
| len_i | input | CNT_W | Number of bytes to write |
| in_data_i | input | 8 | Payload byte from the source |
| in_valid_i | input | 1 | Source has a byte |
| in_ready_o | output | 1 | Block accepts the byte this cycle |
| spi_sck_o | output | 1 | Serial clock |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the device |
| spi_miso_i | input | 1 | Serial data from the device |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (held) |
| timeout_o | output | 1 | Operation aborted on a poll timeout (held) |

## Verification
The bench sweeps start addresses on both sides of a page edge (0, 1, 63, 100) against counts of 1, 3, 64, 65 and 129 bytes, in both normal and erase mode. A behavioural device model wraps writes within a page, so a burst that crossed a boundary, a swapped address byte or a least-significant-first shifter would corrupt the expected image. The model keeps reporting busy for two reads before every write. A design that skipped the initial poll or any post-burst poll would be caught when it issues a write-enable while busy. Counting status frames also exposes a poll loop that stops one read early or late. A device held busy forever must produce exactly POLL_MAX status frames, followed by done together with timeout. A zero count must end after a single status frame, and a start pulsed mid-operation must leave the image untouched.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;

  localparam int ADDR_W = 16;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_PROG    = 8'h02;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] BYTE_ERASE = 8'hFF;
  localparam logic [7:0] BYTE_DUMMY = 8'h00;

  typedef enum logic [3:0] {
    S_IDLE,
    S_GAP,
    S_RS_OP,
    S_RS_DUM,
    S_WE_OP,
    S_PG_OP,
    S_AD_HI,
    S_AD_LO,
    S_DT_WAIT,
    S_DT_SHIFT
  } seq_state_e;

  typedef enum logic [1:0] {
    FR_POLL,
    FR_WREN,
    FR_PROG
  } frame_kind_e;

endpackage

// File: rtl/ee_spi_shifter.sv
module ee_spi_shifter #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             act_q, act_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       rx_q, rx_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    div_d  = div_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (go_i) begin
        act_d = 1'b1;
        sh_d  = tx_i;
        bit_d = 3'd0;
        div_d = '0;
        sck_d = 1'b0;
      end
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
      end else begin
        sck_d = 1'b0;
        rx_d  = {rx_q[6:0], miso_i};
        sh_d  = {sh_q[6:0], 1'b0};
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
        end
      end
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= 3'd0;
      sh_q   <= 8'd0;
      rx_q   <= 8'd0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;

endmodule

// File: rtl/ee_wr_seq.sv
module ee_wr_seq
  import ee_wr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PAGE_W   = 6,
  parameter int CS_GAP   = 4,
  parameter int POLL_MAX = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              sh_go_o,
  output logic [7:0]        sh_tx_o,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              cs_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(POLL_MAX + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(CS_GAP - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

  seq_state_e        st_q, st_d;
  frame_kind_e       fr_q, fr_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              erase_q, erase_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic              go_q, go_d;
  logic [7:0]        tx_q, tx_d;
  logic              cs_q, cs_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              to_q, to_d;
  logic              ready;

  assign addr_nx = addr_q + ADDR_W'(1);

  always_comb begin
    st_d    = st_q;
    fr_d    = fr_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    erase_d = erase_q;
    gap_d   = gap_q;
    poll_d  = poll_q;
    go_d    = 1'b0;
    tx_d    = tx_q;
    cs_d    = cs_q;
    busy_d  = busy_q;
    done_d  = done_q;
    to_d    = to_q;
    ready   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          busy_d  = 1'b1;
          done_d  = 1'b0;
          to_d    = 1'b0;
          addr_d  = addr_i;
          cnt_d   = len_i;
          erase_d = erase_i;
          fr_d    = FR_POLL;
          poll_d  = '0;
          gap_d   = '0;
          cs_d    = 1'b1;
          st_d    = S_GAP;
        end
      end
      S_GAP: begin
        if (gap_q == GAP_LAST) begin
          cs_d = 1'b0;
          go_d = 1'b1;
          unique case (fr_q)
            FR_WREN: begin tx_d = OP_WREN; st_d = S_WE_OP; end
            FR_PROG: begin tx_d = OP_PROG; st_d = S_PG_OP; end
            default: begin tx_d = OP_RDSR; st_d = S_RS_OP; end
          endcase
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      S_RS_OP: begin
        if (sh_done_i) begin
          go_d = 1'b1;
          tx_d = BYTE_DUMMY;
          st_d = S_RS_DUM;
        end
      end
      S_RS_DUM: begin
        if (sh_done_i) begin
          cs_d  = 1'b1;
          gap_d = '0;
          if (!sh_rx_i[0]) begin
            poll_d = '0;
            if (cnt_q == '0) begin
              busy_d = 1'b0;
              done_d = 1'b1;
              st_d   = S_IDLE;
            end else begin
              fr_d = FR_WREN;
              st_d = S_GAP;
            end
          end else if (poll_q == POLL_LAST) begin
            busy_d = 1'b0;
            done_d = 1'b1;
            to_d   = 1'b1;
            st_d   = S_IDLE;
          end else begin
            poll_d = poll_q + POLL_W'(1);
            fr_d   = FR_POLL;
            st_d   = S_GAP;
          end
        end
      end
      S_WE_OP: begin
        if (sh_done_i) begin
          cs_d  = 1'b1;
          gap_d = '0;
          fr_d  = FR_PROG;
          st_d  = S_GAP;
        end
      end
      S_PG_OP: begin
        if (sh_done_i) begin
          go_d = 1'b1;
          tx_d = addr_q[15:8];
          st_d = S_AD_HI;
        end
      end
      S_AD_HI: begin
        if (sh_done_i) begin
          go_d = 1'b1;
          tx_d = addr_q[7:0];
          st_d = S_AD_LO;
        end
      end
      S_AD_LO: begin
        if (sh_done_i) st_d = S_DT_WAIT;
      end
      S_DT_WAIT: begin
        if (erase_q) begin
          go_d = 1'b1;
          tx_d = BYTE_ERASE;
          st_d = S_DT_SHIFT;
        end else if (in_valid_i) begin
          ready = 1'b1;
          go_d  = 1'b1;
          tx_d  = in_data_i;
          st_d  = S_DT_SHIFT;
        end
      end
      S_DT_SHIFT: begin
        if (sh_done_i) begin
          addr_d = addr_nx;
          cnt_d  = cnt_q - CNT_W'(1);
          if ((cnt_q == CNT_W'(1)) || (addr_nx[PAGE_W-1:0] == '0)) begin
            cs_d   = 1'b1;
            gap_d  = '0;
            poll_d = '0;
            fr_d   = FR_POLL;
            st_d   = S_GAP;
          end else begin
            st_d = S_DT_WAIT;
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      fr_q    <= FR_POLL;
      addr_q  <= '0;
      cnt_q   <= '0;
      erase_q <= 1'b0;
      gap_q   <= '0;
      poll_q  <= '0;
      go_q    <= 1'b0;
      tx_q    <= 8'd0;
      cs_q    <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      fr_q    <= fr_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      erase_q <= erase_d;
      gap_q   <= gap_d;
      poll_q  <= poll_d;
      go_q    <= go_d;
      tx_q    <= tx_d;
      cs_q    <= cs_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      to_q    <= to_d;
    end
  end

  assign in_ready_o = ready;
  assign sh_go_o    = go_q;
  assign sh_tx_o    = tx_q;
  assign cs_n_o     = cs_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign timeout_o  = to_q;

endmodule

// File: rtl/spi_ee_page_writer.sv
module spi_ee_page_writer
  import ee_wr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PAGE_W   = 6,
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 4,
  parameter int POLL_MAX = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              spi_sck_o,
  output logic              spi_cs_n_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  logic       rst_meta_q, rst_sync_n;
  logic       sh_go, sh_done;
  logic [7:0] sh_tx, sh_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ee_wr_seq #(
    .CNT_W    (CNT_W),
    .PAGE_W   (PAGE_W),
    .CS_GAP   (CS_GAP),
    .POLL_MAX (POLL_MAX)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .erase_i    (erase_i),
    .addr_i     (addr_i),
    .len_i      (len_i),
    .in_data_i  (in_data_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .sh_go_o    (sh_go),
    .sh_tx_o    (sh_tx),
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx),
    .cs_n_o     (spi_cs_n_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o)
  );

  ee_spi_shifter #(
    .HALF_DIV (HALF_DIV)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .go_i   (sh_go),
    .tx_i   (sh_tx),
    .miso_i (spi_miso_i),
    .sck_o  (spi_sck_o),
    .mosi_o (spi_mosi_o),
    .done_o (sh_done),
    .rx_o   (sh_rx)
  );

endmodule

// File: rtl/ee_wr_checker.sv
module ee_wr_checker #(
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic spi_sck_o,
  input logic spi_cs_n_o,
  input logic spi_mosi_o,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o
);

  localparam int GW = $clog2(CS_GAP + 2);

  logic [GW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= '0;
    end else if (!spi_cs_n_o) begin
      hi_cnt_q <= '0;
    end else if (hi_cnt_q < GW'(CS_GAP)) begin
      hi_cnt_q <= hi_cnt_q + GW'(1);
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> spi_cs_n_o); // R1

  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n_o |-> !spi_sck_o); // R6

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o)); // R6

  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> (in_valid_i && !spi_cs_n_o && busy_o)); // R8

  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (done_o && spi_cs_n_o)); // R9

  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n_o) |-> (hi_cnt_q >= GW'(CS_GAP))); // R10

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R11

endmodule

bind spi_ee_page_writer ee_wr_checker #(.CS_GAP(CS_GAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_i    (start_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .spi_sck_o  (spi_sck_o),
  .spi_cs_n_o (spi_cs_n_o),
  .spi_mosi_o (spi_mosi_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o)
);

// File: tb/spi_ee_page_writer_tb.sv
module spi_ee_page_writer_tb;

  localparam int HALF = 1;
  localparam int GAP  = 3;
  localparam int PMAX = 6;
  localparam int BUSY_N = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        erase = 1'b0;
  logic [15:0] addr = 16'd0;
  logic [15:0] len = 16'd0;
  logic [7:0]  in_data = 8'd0;
  logic        in_valid = 1'b0;
  logic        in_ready, sck, cs_n, mosi, miso, busy, done, tmo;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_ee_page_writer #(
    .CNT_W(16), .PAGE_W(6), .HALF_DIV(HALF), .CS_GAP(GAP), .POLL_MAX(PMAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .erase_i(erase),
    .addr_i(addr), .len_i(len), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .spi_sck_o(sck), .spi_cs_n_o(cs_n),
    .spi_mosi_o(mosi), .spi_miso_i(miso), .busy_o(busy), .done_o(done),
    .timeout_o(tmo)
  );

  // device model
  logic [7:0]  mem [256];
  logic [7:0]  shreg = 8'd0;
  logic [7:0]  opcode = 8'd0;
  logic [15:0] wr_addr = 16'd0;
  int bit_idx = 0, byte_idx = 0;
  int busy_left = 0;
  bit wel = 1'b0;
  int prog_frames = 0, rdsr_frames = 0, viol = 0, gap_viol = 0;
  logic [7:0] stat;

  assign stat = {6'd0, wel, (busy_left != 0)};
  assign miso = (!cs_n && opcode == 8'h05 && byte_idx == 1) ? stat[7 - bit_idx] : 1'b0;

  always @(negedge cs_n) begin
    bit_idx = 0; byte_idx = 0; opcode = 8'd0;
  end

  always @(posedge cs_n) begin
    if (bit_idx != 0) viol++;
    if (opcode == 8'h02 && byte_idx >= 3) begin
      busy_left = BUSY_N;
      wel = 1'b0;
    end
    opcode = 8'd0;
  end

  always @(posedge sck) if (!cs_n) shreg = {shreg[6:0], mosi};

  always @(negedge sck) begin
    if (!cs_n) begin
      if (bit_idx == 7) begin
        if (byte_idx == 0) begin
          opcode = shreg;
          if (shreg == 8'h06) begin
            if (busy_left != 0) viol++;
            wel = 1'b1;
          end else if (shreg == 8'h02) begin
            if (!wel || busy_left != 0) viol++;
            prog_frames++;
          end else if (shreg == 8'h05) begin
            rdsr_frames++;
          end else viol++;
        end else if (opcode == 8'h02) begin
          if (byte_idx == 1) wr_addr[15:8] = shreg;
          else if (byte_idx == 2) wr_addr[7:0] = shreg;
          else begin
            mem[wr_addr[7:0]] = shreg;
            wr_addr[5:0] = wr_addr[5:0] + 6'd1;
          end
        end else if (opcode == 8'h05) begin
          if (byte_idx == 1 && busy_left > 0 && busy_left < 1000) busy_left--;
        end else viol++;
        bit_idx = 0;
        byte_idx++;
      end else bit_idx++;
    end
  end

  // chip-select high time measured by the bench
  int hi_cnt = 0;
  always @(posedge clk) begin
    if (cs_n) hi_cnt++;
    else begin
      if (hi_cnt != 0 && hi_cnt < GAP) gap_viol++;
      hi_cnt = 0;
    end
  end

  // source
  int src_idx = 0, hs = 0, run_id = 0, cyc = 0;
  function automatic logic [7:0] pat(int r, int i);
    return 8'((i * 37 + r * 11 + 5) & 255);
  endfunction

  always @(negedge clk) begin
    cyc++;
    in_valid = (cyc % 5) != 2;
    in_data  = pat(run_id, src_idx);
  end

  always @(posedge clk) begin
    if (in_valid && in_ready) begin
      src_idx <= src_idx + 1;
      hs <= hs + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input int limit, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic launch(input int a, input int n, input bit er);
    @(negedge clk);
    addr = 16'(a); len = 16'(n); erase = er; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic prep(input int r, input int busy0);
    for (int i = 0; i < 256; i++) mem[i] = 8'(8'hA5 ^ i);
    busy_left = busy0; prog_frames = 0; rdsr_frames = 0; viol = 0; gap_viol = 0;
    run_id = r;
    @(negedge clk);
    src_idx = 0; hs = 0;
  endtask

  task automatic do_run(input int a, input int n, input bit er, input int r, input bit poke);
    bit ok;
    int bursts, bad;
    prep(r, BUSY_N);
    launch(a, n, er);
    chk(busy == 1'b1 && done == 1'b0, "R11 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      addr = 16'd200; len = 16'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(20000, ok);
    chk(ok && !tmo && !busy && cs_n, "R11 completion", int'(tmo), 0);
    bursts = (n == 0) ? 0 : ((a + n - 1) >> 6) - (a >> 6) + 1;
    chk(prog_frames == bursts, "R4 program frames", prog_frames, bursts);
    chk(rdsr_frames == (BUSY_N + 1) * (bursts + 1), "R5 status frames",
        rdsr_frames, (BUSY_N + 1) * (bursts + 1));
    chk(viol == 0, "R2/R3 protocol order (R2 R3 R6)", viol, 0);
    chk(gap_viol == 0, "R10 cs high gap", gap_viol, 0);
    chk(hs == (er ? 0 : n), er ? "R7 erase takes no source bytes" : "R8 bytes accepted",
        hs, er ? 0 : n);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      if (i >= a && i < a + n) e = er ? 8'hFF : pat(r, i - a);
      else e = 8'(8'hA5 ^ i);
      if (mem[i] !== e) bad++;
    end
    chk(bad == 0, er ? "R7 erased image" : "R4 R6 R8 written image", bad, 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r;
    bit ok;
    int as [4] = '{0, 1, 63, 100};
    int ls [5] = '{1, 3, 64, 65, 129};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sck == 1'b0, "R1 pins idle", int'(cs_n), 1);
    chk(!busy && !done && !tmo && !in_ready, "R1 flags idle", int'(busy | done | tmo), 0);

    r = 0;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 5; j++) begin
        r++;
        do_run(as[i], ls[j], ((i + j) % 3) == 0, r, (i == 1 && j == 4));
      end
    end

    // zero count: single initial poll only (R4, R2)
    prep(90, 0);
    launch(10, 0, 1'b0);
    wait_done(5000, ok);
    chk(ok && !tmo, "R4 zero count completes", int'(ok), 1);
    chk(rdsr_frames == 1 && prog_frames == 0, "R2 zero count one poll", rdsr_frames, 1);

    // poll timeout (R9)
    prep(91, 1000);
    launch(5, 4, 1'b0);
    wait_done(20000, ok);
    chk(ok && tmo == 1'b1, "R9 timeout flagged", int'(tmo), 1);
    chk(rdsr_frames == PMAX, "R9 poll attempts", rdsr_frames, PMAX);
    chk(prog_frames == 0 && cs_n == 1'b1 && !busy, "R9 aborted with cs high", prog_frames, 0);
    repeat (5) @(negedge clk);
    chk(done && tmo, "R11 flags held", int'(done & tmo), 1);

    // flags cleared by next start, normal run afterwards
    busy_left = 0;
    do_run(2, 3, 1'b0, 92, 1'b0);
    chk(!tmo, "R11 timeout cleared by start", int'(tmo), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule